// File: doc/BRIEF.md
# Dual Offset Pseudo-Noise Stream Generator

The block drives two pseudo-noise bit streams. Each comes from its own 31-stage maximal-length shift register with feedback taps at stages 31 and 3, so each stream repeats only after 2,147,483,647 steps. The two registers are identical and start from the same seed. The second stream is a copy of the first that runs a fixed number of steps ahead of it.

After reset the block spends one clock per pre-advance step moving the second register forward on its own. During that time it reports not-ready and ignores step requests. After that, each accepted step request advances the first register, and on the next clock the second register. A strobe marks each step: it is high from the first update until the second output has moved. A consumer that samples both outputs when the strobe falls sees two streams that keep a constant lag between them.

Top module: `dual_pn_gen`

## Requirements
- R1: While reset is high, and on the first clock after reset is released, `ready`, `strobe`, `pn_a` and `pn_b` are all 0. Both registers are loaded with the seed 0x40004000, and a reset takes effect on a rising clock edge.
- R2: `ready` goes high exactly LEAD_STEPS clocks after the first clock edge that sees reset low. With the default, that is 625 clocks. Once high, it stays high until the next reset.
- R3: While `ready` is low, `step_en` is ignored: `strobe` stays 0 and `pn_a` and `pn_b` keep their values.
- R4: Each register advances by shifting its word left by one place and loading bit 30 XOR bit 2 of the old word into bit 0. A step request is accepted on a clock edge where `ready` is 1, `step_en` is 1 and `strobe` is 0. After that edge, `strobe` is 1 and `pn_a` equals bit 0 of the first register's new word, while `pn_b` is unchanged.
- R5: On the clock after the strobe rises, the second register advances, `pn_b` becomes bit 0 of its new word, `strobe` returns to 0 and `pn_a` stays unchanged.
- R6: A `step_en` that is high while `strobe` is 1 is ignored. It causes no extra advance of either register.
- R7: For every step index k, the value of `pn_b` at step k equals the value of `pn_a` at step k + LEAD_STEPS.
- R8: While no step is in progress and none is requested, both outputs hold their values.
- R9: A reset asserted in the middle of a run reloads the seed and restarts the pre-advance. The streams that follow are identical to those after the first reset.
- R10: The 31 stages of either register are never all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Request one lock-step advance of both streams |
| pn_a | output | 1 | Serial output of the first (lagging) register |
| pn_b | output | 1 | Serial output of the second (leading) register |
| strobe | output | 1 | High from the first register update until the second output is updated |
| ready | output | 1 | High once the pre-advance has finished |

## Verification
An error in the feedback or the shift corrupts bit 0 within a few steps. It shows up as a `pn_a` or `pn_b` bit that differs from the independent model on the first step after the error. An error in the pre-advance count leaves every single stream looking plausible. It is seen only in two places: in the cycle in which `ready` rises, and in the alignment check, where `pn_b` at step k is compared with `pn_a` at step k plus the lead over several hundred steps. An error in the step sequencing shows up within one or two clocks, as a strobe that lasts the wrong number of cycles or an output that moves in the wrong phase.

// File: rtl/dual_pn_gen.sv
module dual_pn_gen #(
  parameter int LEN = 31,
  parameter int TAP_LO = 2,
  parameter logic [LEN-1:0] SEED = 31'h4000_4000,
  parameter int LEAD_STEPS = 625
) (
  input  logic clk,
  input  logic rst,
  input  logic step_en,
  output logic pn_a,
  output logic pn_b,
  output logic strobe,
  output logic ready
);
  localparam int TAP_HI = LEN - 1;
  localparam int CW = ($clog2(LEAD_STEPS + 1) < 1) ? 1 : $clog2(LEAD_STEPS + 1);

  logic [LEN-1:0] reg_a, reg_b, nxt_a, nxt_b;
  logic [CW-1:0]  lead_cnt;
  logic           go;

  function automatic logic [LEN-1:0] adv(input logic [LEN-1:0] s);
    return {s[LEN-2:0], s[TAP_HI] ^ s[TAP_LO]};
  endfunction

  assign nxt_a = adv(reg_a);
  assign nxt_b = adv(reg_b);
  assign ready = (lead_cnt == '0);
  assign go    = ready && step_en && !strobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_a    <= SEED;
      reg_b    <= SEED;
      lead_cnt <= CW'(LEAD_STEPS);
      strobe   <= 1'b0;
      pn_a     <= 1'b0;
      pn_b     <= 1'b0;
    end else if (!ready) begin
      reg_b    <= nxt_b;
      lead_cnt <= lead_cnt - 1'b1;
    end else if (go) begin
      reg_a    <= nxt_a;
      pn_a     <= nxt_a[0];
      strobe   <= 1'b1;
    end else if (strobe) begin
      reg_b    <= nxt_b;
      pn_b     <= nxt_b[0];
      strobe   <= 1'b0;
    end
  end

  AST_READY_STAYS: assert property (@(posedge clk) disable iff (rst) ready |=> ready); // R2
  AST_PRE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ready |=> (!strobe && $stable(pn_a) && $stable(pn_b))); // R3
  AST_ACCEPT_A: assert property (@(posedge clk) disable iff (rst)
    (ready && step_en && !strobe) |=> (strobe && $stable(pn_b))); // R4
  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (!strobe && $stable(pn_a))); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!strobe && !(ready && step_en)) |=> ($stable(pn_a) && $stable(pn_b) && !strobe)); // R8
  AST_NONZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_a != '0) && (reg_b != '0)); // R10
endmodule

// File: tb/dual_pn_gen_test.sv
module dual_pn_gen_test;
  localparam int LEAD = 625;
  localparam int NSTEPS = 900;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_en = 1'b0;
  logic pn_a, pn_b, strobe, ready;
  int checks = 0;
  int errors = 0;
  logic [31:0] ma, mb;
  logic a_hist [0:NSTEPS-1];
  logic b_hist [0:NSTEPS-1];

  always #2.5 clk = ~clk;

  dual_pn_gen uut (.clk(clk), .rst(rst), .step_en(step_en), .pn_a(pn_a),
                   .pn_b(pn_b), .strobe(strobe), .ready(ready));

  function automatic logic [31:0] mstep(input logic [31:0] s);
    return {s[30:0], s[30] ^ s[2]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc;
    @(negedge clk);
  endtask

  task automatic model_reset;
    ma = 32'h4000_4000;
    mb = 32'h4000_4000;
    for (int i = 0; i < LEAD; i++) mb = mstep(mb);
  endtask

  task automatic do_reset_and_lead;
    rst = 1'b1; step_en = 1'b0;
    cyc; cyc;
    chk("R1 ready", ready, 0); chk("R1 strobe", strobe, 0);
    chk("R1 pn_a", pn_a, 0); chk("R1 pn_b", pn_b, 0);
    rst = 1'b0;
    step_en = 1'b1;
    for (int k = 1; k <= LEAD; k++) begin
      cyc;
      if (k == 1) begin
        chk("R1 ready", ready, 0); chk("R1 pn_a", pn_a, 0); chk("R1 pn_b", pn_b, 0);
      end
      if (k == LEAD - 1) chk("R2 ready early", ready, 0);
      if (k == LEAD) chk("R2 ready on time", ready, 1);
      if (k < LEAD && (strobe !== 1'b0 || pn_a !== 1'b0 || pn_b !== 1'b0)) begin
        chk("R3 quiet in pre-advance", {strobe, pn_a, pn_b}, 0);
      end
    end
    chk("R3 outputs after pre-advance", {strobe, pn_a, pn_b}, 0);
    step_en = 1'b0;
    model_reset;
  endtask

  task automatic do_step(input int idx, input bit verbose);
    logic pb_old;
    pb_old = pn_b;
    step_en = 1'b1;
    cyc;
    step_en = 1'b0;
    ma = mstep(ma);
    mb = mstep(mb);
    if (verbose || strobe !== 1'b1 || pn_a !== ma[0] || pn_b !== pb_old) begin
      chk("R4 strobe", strobe, 1); chk("R4 pn_a", pn_a, ma[0]); chk("R4 pn_b held", pn_b, pb_old);
    end
    cyc;
    if (verbose || strobe !== 1'b0 || pn_a !== ma[0] || pn_b !== mb[0]) begin
      chk("R5 strobe low", strobe, 0); chk("R5 pn_b", pn_b, mb[0]); chk("R5 pn_a held", pn_a, ma[0]);
    end
    if (idx >= 0 && idx < NSTEPS) begin
      a_hist[idx] = pn_a;
      b_hist[idx] = pn_b;
    end
  endtask

  task automatic test_basic;
    do_reset_and_lead;
    for (int i = 0; i < 4; i++) do_step(-1, 1'b1);
  endtask

  task automatic test_hold;
    logic a0, b0;
    a0 = pn_a; b0 = pn_b;
    for (int i = 0; i < 5; i++) cyc;
    chk("R8 pn_a hold", pn_a, a0); chk("R8 pn_b hold", pn_b, b0); chk("R8 strobe", strobe, 0);
  endtask

  task automatic test_busy_ignore;
    step_en = 1'b1;
    cyc;
    cyc;
    step_en = 1'b0;
    ma = mstep(ma); mb = mstep(mb);
    chk("R6 strobe low", strobe, 0);
    cyc; cyc;
    chk("R6 pn_a", pn_a, ma[0]); chk("R6 pn_b", pn_b, mb[0]);
    do_step(-1, 1'b1);
  endtask

  task automatic test_lag;
    int bad;
    do_reset_and_lead;
    for (int i = 0; i < NSTEPS; i++) do_step(i, 1'b0);
    bad = 0;
    for (int k = 0; k + LEAD < NSTEPS; k++) if (b_hist[k] !== a_hist[k + LEAD]) bad++;
    chk("R7 lag mismatches", bad, 0);
  endtask

  task automatic test_midreset;
    logic [7:0] first, second;
    do_reset_and_lead;
    for (int i = 0; i < 8; i++) begin do_step(-1, 1'b0); first[i] = pn_b; end
    do_reset_and_lead;
    chk("R9 ready after reload", ready, 1);
    for (int i = 0; i < 8; i++) begin do_step(-1, 1'b0); second[i] = pn_b; end
    chk("R9 repeat stream", second, first);
  endtask

  initial begin
    test_basic;
    test_hold;
    test_busy_ignore;
    test_lag;
    test_midreset;
    chk("R10 model state nonzero", (ma[30:0] != 0) && (mb[30:0] != 0), 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule